// File: doc/BRIEF.md
# System Tick Down-Counter Timer

A 24-bit periodic down-counting timer behind a small synchronous register bus. Software writes a reload value, clears the counter, selects a count source and enables counting. The counter steps down by one on each counting clock. When it steps from 1 to 0 it raises a sticky event flag. On the following counting clock it loads the reload value again, so events repeat every reload+1 counting clocks.

The count source is either every core clock or the rising edges of a slower reference input. That input is brought in through a two-flop synchronizer and an edge detector. The event flag is cleared by any read of the control word. A level interrupt request follows the flag when the interrupt enable is set. A read-only calibration word reports a 10 ms tick count together with an inexact-count flag and a no-reference flag. Build parameters can force the core clock as source and can report the count as unknown (zero).

Top module: `sys_tick_timer`

## Requirements
- R1: The reload register (word index 1) stores wdata bits [23:0]. It reads back zero-extended, and bits [31:24] of a write are dropped.
- R2: With counting enabled, a counting clock at count 0 loads the reload value. At any other count it decrements by one. The event is the 1-to-0 step, so after a clear the first event comes on counting clock reload+1 and then every reload+1 counting clocks.
- R3: Control bit 0 enables counting. While it is 0 the current value (word index 2) holds.
- R4: Control bit 16 is set by each event and cleared by a read of the control word (word index 0). An event in the same cycle as that read leaves the bit set.
- R5: irq_o is high exactly while control bit 16 and control bit 1 are both 1. It is low while bit 1 is 0.
- R6: When control bit 2 is 0, each rising edge of ref_clk_i yields exactly one counting clock, a few core cycles later. No counting happens without edges.
- R7: Any write to word index 2 sets the counter to 0 and clears bit 16, even if an event would occur in that cycle. The write raises no event.
- R8: A reload value of 0 produces no events, and the counter stays at 0.
- R9: Word index 3 is read-only. It holds the 10 ms count in bits [23:0] (or zero when the count-unknown option is set), the inexact flag in bit 30 and the no-reference flag in bit 31.
- R10: With the force-core option, control bit 2 reads 1 regardless of writes and the core clock drives counting.
- R11: After reset all control bits, the reload value, the counter and irq_o are 0, apart from a forced bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_clk_i | input | 1 | Slow reference input, asynchronous |
| req_i | input | 1 | Bus access strobe, one access per cycle |
| we_i | input | 1 | 1 for write, 0 for read |
| addr_i | input | 2 | Word index: 0 control, 1 reload, 2 current, 3 calibration |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| irq_o | output | 1 | Level interrupt request |

## Verification
Two functions can land on the same core edge: the 1-to-0 event that sets the flag, and a bus access that clears it. The access is either a control-word read or a current-value write. The bench counts cycles from enable so that a control read falls exactly on the event edge. It then expects the flag to be reported set on the next read and clear on the one after. In a separate run, a current-value write is placed on that same edge, and the bench expects the flag to stay clear and the counter to restart from 0 with a reload one cycle later.

// File: rtl/tick_pkg.sv
package tick_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL    = 2'd0,
    REG_RELOAD  = 2'd1,
    REG_CURRENT = 2'd2,
    REG_CALIB   = 2'd3
  } tick_reg_e;

  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_IRQ_BIT  = 1;
  localparam int CTRL_SRC_BIT  = 2;
  localparam int CTRL_FLAG_BIT = 16;
  localparam int CAL_SKEW_BIT  = 30;
  localparam int CAL_NOREF_BIT = 31;
endpackage

// File: rtl/tick_ref_sync.sv
module tick_ref_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref_i,
  output logic pulse_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   last_q;

  for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_stage
    logic d;
    if (i == 0) begin : g_first
      assign d = ref_i;
    end else begin : g_next
      assign d = sync_q[i-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sync_q[i] <= 1'b0;
      else         sync_q[i] <= d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) last_q <= 1'b0;
    else         last_q <= sync_q[SYNC_STAGES-1];
  end

  assign pulse_o = sync_q[SYNC_STAGES-1] & ~last_q;
endmodule

// File: rtl/tick_down_counter.sv
module tick_down_counter #(
  parameter int CNT_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic             clear_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             evt_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cnt_q <= '0;
    else if (clear_i)    cnt_q <= '0;
    else if (step_i) begin
      if (cnt_q == '0)   cnt_q <= reload_i;
      else               cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  // clear takes priority: no event on the edge a clear lands
  assign evt_o = step_i & ~clear_i & (cnt_q == CNT_W'(1));
  assign cnt_o = cnt_q;
endmodule

// File: rtl/tick_csr.sv
module tick_csr
  import tick_pkg::*;
#(
  parameter int               CNT_W          = 24,
  parameter logic [CNT_W-1:0] CAL_TENMS      = '0,
  parameter bit               CAL_SKEW       = 1'b0,
  parameter bit               CAL_NOREF      = 1'b0,
  parameter bit               CAL_UNKNOWN    = 1'b0,
  parameter bit               FORCE_CORE_CLK = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              evt_i,
  output logic              en_o,
  output logic              tickint_o,
  output logic              src_core_o,
  output logic [CNT_W-1:0]  reload_o,
  output logic              flag_o,
  output logic              cur_wr_o,
  output logic              ctrl_rd_o,
  output logic [DATA_W-1:0] rdata_o
);
  tick_reg_e        reg_sel;
  logic             wr, rd, ctrl_wr, reload_wr;
  logic             en_q, tickint_q, src_q, flag_q;
  logic [CNT_W-1:0] reload_q;
  logic             unused_wdata;

  assign reg_sel   = tick_reg_e'(addr_i);
  assign wr        = req_i & we_i;
  assign rd        = req_i & ~we_i;
  assign ctrl_wr   = wr & (reg_sel == REG_CTRL);
  assign reload_wr = wr & (reg_sel == REG_RELOAD);
  assign cur_wr_o  = wr & (reg_sel == REG_CURRENT);
  assign ctrl_rd_o = rd & (reg_sel == REG_CTRL);
  assign unused_wdata = ^wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q      <= 1'b0;
      tickint_q <= 1'b0;
      reload_q  <= '0;
    end else begin
      if (ctrl_wr) begin
        en_q      <= wdata_i[CTRL_EN_BIT];
        tickint_q <= wdata_i[CTRL_IRQ_BIT];
      end
      if (reload_wr) reload_q <= wdata_i[CNT_W-1:0];
    end
  end

  if (FORCE_CORE_CLK) begin : g_src_forced
    assign src_q = 1'b1;
  end else begin : g_src_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      src_q <= 1'b0;
      else if (ctrl_wr) src_q <= wdata_i[CTRL_SRC_BIT];
    end
  end

  // current-value write beats event, event beats read-clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        flag_q <= 1'b0;
    else if (cur_wr_o)  flag_q <= 1'b0;
    else if (evt_i)     flag_q <= 1'b1;
    else if (ctrl_rd_o) flag_q <= 1'b0;
  end

  always_comb begin
    rdata_o = '0;
    case (reg_sel)
      REG_CTRL: begin
        rdata_o[CTRL_EN_BIT]   = en_q;
        rdata_o[CTRL_IRQ_BIT]  = tickint_q;
        rdata_o[CTRL_SRC_BIT]  = src_q;
        rdata_o[CTRL_FLAG_BIT] = flag_q;
      end
      REG_RELOAD:  rdata_o[CNT_W-1:0] = reload_q;
      REG_CURRENT: rdata_o[CNT_W-1:0] = cnt_i;
      REG_CALIB: begin
        rdata_o[CNT_W-1:0]   = CAL_UNKNOWN ? '0 : CAL_TENMS;
        rdata_o[CAL_SKEW_BIT]  = CAL_SKEW;
        rdata_o[CAL_NOREF_BIT] = CAL_NOREF;
      end
      default: rdata_o = '0;
    endcase
  end

  assign en_o       = en_q;
  assign tickint_o  = tickint_q;
  assign src_core_o = src_q;
  assign reload_o   = reload_q;
  assign flag_o     = flag_q;
endmodule

// File: rtl/sys_tick_timer.sv
module sys_tick_timer
  import tick_pkg::*;
#(
  parameter int               CNT_W          = 24,
  parameter logic [CNT_W-1:0] CAL_TENMS      = CNT_W'(120000),
  parameter bit               CAL_SKEW       = 1'b1,
  parameter bit               CAL_NOREF      = 1'b0,
  parameter bit               CAL_UNKNOWN    = 1'b0,
  parameter bit               FORCE_CORE_CLK = 1'b0,
  parameter int               SYNC_STAGES    = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        ref_clk_i,
  input  logic        req_i,
  input  logic        we_i,
  input  logic [1:0]  addr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  output logic        irq_o
);
  logic             ref_pulse;
  logic             en_q, tickint_q, src_core, flag_q;
  logic             cur_wr, ctrl_rd, cnt_en, tick_evt;
  logic [CNT_W-1:0] reload_q, cnt_q;

  tick_ref_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ref_i   (ref_clk_i),
    .pulse_o (ref_pulse)
  );

  assign cnt_en = en_q & (src_core | ref_pulse);

  tick_down_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .step_i   (cnt_en),
    .clear_i  (cur_wr),
    .reload_i (reload_q),
    .cnt_o    (cnt_q),
    .evt_o    (tick_evt)
  );

  tick_csr #(
    .CNT_W          (CNT_W),
    .CAL_TENMS      (CAL_TENMS),
    .CAL_SKEW       (CAL_SKEW),
    .CAL_NOREF      (CAL_NOREF),
    .CAL_UNKNOWN    (CAL_UNKNOWN),
    .FORCE_CORE_CLK (FORCE_CORE_CLK)
  ) u_csr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .we_i       (we_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .cnt_i      (cnt_q),
    .evt_i      (tick_evt),
    .en_o       (en_q),
    .tickint_o  (tickint_q),
    .src_core_o (src_core),
    .reload_o   (reload_q),
    .flag_o     (flag_q),
    .cur_wr_o   (cur_wr),
    .ctrl_rd_o  (ctrl_rd),
    .rdata_o    (rdata_o)
  );

  assign irq_o = flag_q & tickint_q;
endmodule

// File: rtl/sys_tick_timer_chk.sv
module sys_tick_timer_chk #(
  parameter int CNT_W = 24
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             irq_o,
  input logic             ref_pulse,
  input logic             cnt_en,
  input logic             tick_evt,
  input logic             cur_wr,
  input logic             ctrl_rd,
  input logic             flag_q,
  input logic             tickint_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] reload_q
);
  assert_wrap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_en && cnt_q == '0 && !cur_wr) |=> cnt_q == $past(reload_q));

  assert_dec_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_en && cnt_q != '0 && !cur_wr) |=> cnt_q == $past(cnt_q) - CNT_W'(1));

  assert_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cnt_en && !cur_wr) |=> $stable(cnt_q));

  assert_flag_src_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_q) |-> $past(tick_evt));

  assert_read_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_rd && !tick_evt && !cur_wr) |=> !flag_q);

  assert_irq_gate_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> tickint_q);

  assert_ref_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_pulse |=> !ref_pulse);

  assert_cur_wr_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cur_wr |=> (cnt_q == '0 && !flag_q));

  assert_zero_reload_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reload_q == '0 && cnt_q == '0) |=> !$rose(flag_q));
endmodule

bind sys_tick_timer sys_tick_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .irq_o     (irq_o),
  .ref_pulse (ref_pulse),
  .cnt_en    (cnt_en),
  .tick_evt  (tick_evt),
  .cur_wr    (cur_wr),
  .ctrl_rd   (ctrl_rd),
  .flag_q    (flag_q),
  .tickint_q (tickint_q),
  .cnt_q     (cnt_q),
  .reload_q  (reload_q)
);

// File: tb/sim_sys_tick_timer.sv
module sim_sys_tick_timer;
  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] A_CTRL = 2'd0, A_RLD = 2'd1, A_CUR = 2'd2, A_CAL = 2'd3;

  logic        clk, rst_n, ref_clk, req, we;
  logic [1:0]  addr;
  logic [31:0] wdata, rdata0, rdata1, rd0, rd1;
  logic        irq0, irq1;
  int          n_chk = 0, n_fail = 0;
  bit          done = 0;

  sys_tick_timer u0 (
    .clk_i(clk), .rst_ni(rst_n), .ref_clk_i(ref_clk), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata0), .irq_o(irq0)
  );

  sys_tick_timer #(.FORCE_CORE_CLK(1'b1), .CAL_UNKNOWN(1'b1)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .ref_clk_i(ref_clk), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata1), .irq_o(irq1)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // called just after a negedge; returns at the next negedge
  task automatic acc(input logic w, input logic [1:0] a, input logic [31:0] d);
    req = 1'b1; we = w; addr = a; wdata = d;
    #1;
    rd0 = rdata0; rd1 = rdata1;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setup(input int r, input logic [31:0] ctrl);
    acc(1'b1, A_CTRL, 32'h0);
    acc(1'b1, A_RLD, 32'(r));
    acc(1'b1, A_CUR, 32'h0);
    acc(1'b1, A_CTRL, ctrl);
  endtask

  function automatic logic [31:0] exp_val(input int r, input int k);
    if (k == 0) return 32'h0;
    return 32'(r - ((k - 1) % (r + 1)));
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=hung exp=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] first;
    rst_n = 1'b0; ref_clk = 1'b0; req = 1'b0; we = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state, R10 forced source bit
    chk("R11 irq", {31'b0, irq0}, 32'h0);
    acc(1'b0, A_CTRL, 0); chk("R11 ctrl", rd0, 32'h0); chk("R10 ctrl forced", rd1, 32'h4);
    acc(1'b0, A_RLD, 0);  chk("R11 reload", rd0, 32'h0);
    acc(1'b0, A_CUR, 0);  chk("R11 current", rd0, 32'h0);

    // R9 calibration, read-only
    acc(1'b0, A_CAL, 0);  chk("R9 calib", rd0, 32'h4001_D4C0); chk("R9 calib unknown", rd1, 32'h4000_0000);
    acc(1'b1, A_CAL, 32'h0);
    acc(1'b0, A_CAL, 0);  chk("R9 calib after write", rd0, 32'h4001_D4C0);

    // R1 reload width
    acc(1'b1, A_RLD, 32'hFFFF_FFFF); acc(1'b0, A_RLD, 0); chk("R1 reload max", rd0, 32'h00FF_FFFF);
    acc(1'b1, A_RLD, 32'h1234_5678); acc(1'b0, A_RLD, 0); chk("R1 reload trunc", rd0, 32'h0034_5678);

    // R2 period sweep on core clock, R3 hold, R4 read clear
    for (int r = 1; r <= 6; r++) begin
      setup(r, 32'h5);
      for (int k = 0; k <= 3 * r + 4; k++) begin
        chk($sformatf("R5 irq quiet r=%0d k=%0d", r, k), {31'b0, irq0}, 32'h0);
        acc(1'b0, A_CUR, 0);
        chk($sformatf("R2 r=%0d k=%0d", r, k), rd0, exp_val(r, k));
      end
      acc(1'b1, A_CTRL, 32'h4);
      acc(1'b0, A_CUR, 0); first = rd0;
      idle(3);
      acc(1'b0, A_CUR, 0); chk($sformatf("R3 hold r=%0d", r), rd0, first);
      acc(1'b0, A_CTRL, 0); chk($sformatf("R4 flag set r=%0d", r), rd0, 32'h0001_0004);
      acc(1'b0, A_CTRL, 0); chk($sformatf("R4 flag cleared r=%0d", r), rd0, 32'h0000_0004);
    end

    // R8 zero reload
    setup(0, 32'h5);
    for (int k = 0; k < 12; k++) begin
      acc(1'b0, A_CUR, 0); chk($sformatf("R8 k=%0d", k), rd0, 32'h0);
    end
    acc(1'b1, A_CTRL, 32'h0);
    acc(1'b0, A_CTRL, 0); chk("R8 no flag", rd0, 32'h0);

    // R5 interrupt level, reload 3
    setup(3, 32'h7);
    for (int k = 0; k <= 5; k++) begin
      chk($sformatf("R5 irq k=%0d", k), {31'b0, irq0}, {31'b0, k >= 4});
      acc(1'b0, A_CUR, 0);
    end
    chk("R5 irq before read", {31'b0, irq0}, 32'h1);
    acc(1'b0, A_CTRL, 0); chk("R5 read flag", rd0, 32'h0001_0007);
    chk("R5 irq after read", {31'b0, irq0}, 32'h0);
    acc(1'b0, A_CUR, 0);
    chk("R5 irq next event", {31'b0, irq0}, 32'h1);

    // R4 read on the event edge
    setup(3, 32'h5);
    for (int k = 0; k <= 2; k++) acc(1'b0, A_CUR, 0);
    acc(1'b0, A_CTRL, 0); chk("R4 collide read", rd0, 32'h0000_0005);
    acc(1'b0, A_CTRL, 0); chk("R4 event kept", rd0, 32'h0001_0005);
    acc(1'b0, A_CTRL, 0); chk("R4 then cleared", rd0, 32'h0000_0005);

    // R7 current write on the event edge
    setup(3, 32'h5);
    for (int k = 0; k <= 2; k++) acc(1'b0, A_CUR, 0);
    acc(1'b1, A_CUR, 32'h00AB_CDEF);
    acc(1'b0, A_CTRL, 0); chk("R7 no event", rd0, 32'h0000_0005);
    acc(1'b0, A_CUR, 0);  chk("R7 restart", rd0, 32'h3);

    // R6 reference edges, R10 forced core counting
    setup(2, 32'h1);
    idle(10);
    acc(1'b0, A_CUR, 0);
    chk("R6 no edges", rd0, 32'h0);
    chk("R10 core counts", rd1, exp_val(2, 10));
    for (int m = 1; m <= 5; m++) begin
      ref_clk = 1'b1; idle(3);
      ref_clk = 1'b0; idle(3);
      acc(1'b0, A_CUR, 0);
      chk($sformatf("R6 edge m=%0d", m), rd0, exp_val(2, m));
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule